// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port, and decides when the port must interrupt software about slot events. Configuration writes arrive as a dword address, four byte enables and 32 bits of data. A combinational read port returns the current register contents. Event inputs report attention-button presses and presence-detect changes. Separate inputs carry external requests to add a device to the slot or to remove it. The block raises a one-cycle detach request when software powers the slot down. It also raises a one-cycle busy indication when an add or remove request arrives while the electromechanical interlock is engaged.

The interrupt logic is a two-state machine. State `N_QUIET` means the notify condition is false; state `N_RAISED` means it is true. Transition RAISE goes from `N_QUIET` to `N_RAISED`, and transition LOWER goes from `N_RAISED` to `N_QUIET`. Each transition, and also a re-arm inside `N_RAISED`, emits at most one message request. A LOWER caused only by a status clear is silent. The request goes out as a single-cycle MSI-X pulse if MSI-X is enabled, otherwise as an MSI pulse if MSI is enabled. When neither is enabled, a registered INTx level follows the notify condition. The vector number is taken from a flags register.

Register layout (dword `SLOT_ADDR`): slot control in bits 15:0, slot status in bits 31:16. Control bits: 0 button-event enable, 2 presence-change enable, 3 command-done enable, 4 hot-plug interrupt enable, 5 interlock toggle (write-only, reads 0), 8:7 attention indicator (2'b11 = off), 10:9 power indicator (2'b11 = off), 11 power controller (1 = off). Status bits: 0 button pressed, 2 presence changed, 3 command done, 4 presence detected, 5 interlock engaged. Dword `FLAGS_ADDR` holds the interrupt vector in bits `VEC_W-1:0`, written with byte enable 0.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, the slot dword reads 0x00000180 (attention indicator off, every other control and status bit 0), and INTx and both message outputs are 0.
- R2: A write to the slot dword updates only the control bytes whose byte enable is set, and only the writable control bits 0, 2, 3, 4 and 7 to 11; control bit 5 always reads 0.
- R3: Any write whose byte enables touch control byte 0 or 1 is one command and sets status bit 3 (command done) at the same clock edge.
- R4: Writing 1 to control bit 5 toggles status bit 5 (interlock engaged).
- R5: Status bits 0, 2 and 3 are write-1-to-clear through byte enables 2 and 3; status bits 4 and 5 do not change on a status write.
- R6: The notify condition is control bit 4 AND (status AND control AND 0x000D) being non-zero.
- R7: A message request is sent only when the notify condition changes at a clock edge. A fall caused only by a status write is silent, and raising an event bit that is already set sends nothing.
- R8: A message goes out on MSI-X when MSI-X is enabled, otherwise on MSI when MSI is enabled. It lasts one cycle and carries the vector from bits VEC_W-1:0 of dword FLAGS_ADDR.
- R9: With both message paths disabled, INTx is the registered notify condition, and it drops in the cycle after a status clear removes the condition.
- R10: A control write with presence detected, written power controller 1 and written power indicator 2'b11 pulses the detach request, clears status bit 4 and sets status bit 2.
- R11: An accepted add request sets status bits 4, 2 and 0 together; an accepted remove request or a button input sets bit 0; a presence-change input sets bit 2.
- R12: While status bit 5 is set, add and remove requests pulse the busy output and leave the status unchanged.
- R13: An event that arrives in the same cycle as a write-1-to-clear of its bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Write dword address |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | ADDR_W | Read dword address |
| cfg_rdata | output | 32 | Read data (combinational) |
| btn_push | input | 1 | Attention-button event |
| pdc_in | input | 1 | Presence-detect change event |
| add_req | input | 1 | External device-add request |
| remove_req | input | 1 | External device-remove request |
| msix_en | input | 1 | MSI-X delivery enabled |
| msi_en | input | 1 | MSI delivery enabled |
| busy_err | output | 1 | Add or remove rejected, interlock engaged |
| detach_req | output | 1 | Detach the slot's devices |
| msix_req | output | 1 | MSI-X message request pulse |
| msi_req | output | 1 | MSI message request pulse |
| irq_vec | output | VEC_W | Vector carried by the message |
| intx | output | 1 | INTx level |

## Verification
The bench sweeps every combination of interrupt enable, the three event enables and the three event sources, under each delivery mode. It compares the outputs with the notify formula computed in the bench. A design that ignored one enable or mis-masked the status would show a wrong INTx level or a missing pulse in some vector. Directed cases cover the ordering hazards: a repeated event while the condition is already high must send nothing, and a status clear must lower INTx without a message. They also check that an event beats a simultaneous clear, that a lock rejects adds, and that the detach decode uses the written control value rather than the old one.

// File: rtl/hp_pkg.sv
package hp_pkg;
    // control field positions
    localparam int C_BTN_EN   = 0;
    localparam int C_PDC_EN   = 2;
    localparam int C_CMD_EN   = 3;
    localparam int C_HP_EN    = 4;
    localparam int C_LOCK_TGL = 5;
    localparam int C_ATTN_LO  = 7;
    localparam int C_PIND_LO  = 9;
    localparam int C_PWR      = 11;
    // status field positions
    localparam int S_BTN  = 0;
    localparam int S_PDC  = 2;
    localparam int S_CMD  = 3;
    localparam int S_PRES = 4;
    localparam int S_LOCK = 5;

    localparam logic [15:0] EV_MASK   = 16'h000D;
    localparam logic [15:0] CTL_WMASK = 16'h0F9D;
    localparam logic [15:0] CTL_RST   = 16'h0180;

    typedef enum logic {
        N_QUIET  = 1'b0,
        N_RAISED = 1'b1
    } notify_st_t;

    function automatic logic notify_cond(input logic [15:0] ctl, input logic [15:0] sts);
        return ctl[C_HP_EN] && (|(ctl & sts & EV_MASK));
    endfunction
endpackage

// File: rtl/hp_cfg_decode.sv
module hp_cfg_decode
    import hp_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int SLOT_ADDR  = 6,
    parameter int FLAGS_ADDR = 0
) (
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic [15:0]       ctl_q,
    output logic              ctl_hit,
    output logic              sts_hit,
    output logic              vec_we,
    output logic              lock_tgl,
    output logic [15:0]       ctl_wr_val,
    output logic [15:0]       sts_w1c
);
    localparam int NBYTES = 4;

    logic [31:0] be_bits;
    logic        slot_sel;
    logic [15:0] ctl_merged;

    for (genvar b = 0; b < NBYTES; b++) begin : g_be
        assign be_bits[8*b +: 8] = {8{cfg_be[b]}};
    end

    assign slot_sel   = cfg_wr && (cfg_addr == ADDR_W'(SLOT_ADDR));
    assign ctl_hit    = slot_sel && (|cfg_be[1:0]);
    assign sts_hit    = slot_sel && (|cfg_be[3:2]);
    assign vec_we     = cfg_wr && (cfg_addr == ADDR_W'(FLAGS_ADDR)) && cfg_be[0];
    assign lock_tgl   = slot_sel && cfg_be[0] && cfg_wdata[C_LOCK_TGL];
    assign ctl_merged = (cfg_wdata[15:0] & be_bits[15:0]) | (ctl_q & ~be_bits[15:0]);
    assign ctl_wr_val = ctl_merged & CTL_WMASK;
    assign sts_w1c    = sts_hit ? (cfg_wdata[31:16] & be_bits[31:16] & EV_MASK) : 16'h0000;
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_hit,
    input  logic             vec_we,
    input  logic             lock_tgl,
    input  logic [15:0]      ctl_wr_val,
    input  logic [15:0]      sts_w1c,
    input  logic [VEC_W-1:0] vec_wr_val,
    input  logic             btn_push,
    input  logic             pdc_in,
    input  logic             add_req,
    input  logic             remove_req,
    output logic [15:0]      ctl_q,
    output logic [15:0]      sts_q,
    output logic [15:0]      ctl_nxt,
    output logic [15:0]      sts_nxt,
    output logic [15:0]      sts_cleared,
    output logic [VEC_W-1:0] vec_q,
    output logic             detach_req,
    output logic             busy_err
);
    logic locked, add_ok, rem_ok, busy_nxt, detach_nxt;

    assign locked      = sts_q[S_LOCK];
    assign add_ok      = add_req && !locked;
    assign rem_ok      = remove_req && !locked;
    assign busy_nxt    = (add_req || remove_req) && locked;
    assign sts_cleared = sts_q & ~sts_w1c;
    assign detach_nxt  = ctl_hit && sts_q[S_PRES] && ctl_wr_val[C_PWR]
                         && (&ctl_wr_val[C_PIND_LO +: 2]);
    assign ctl_nxt     = ctl_hit ? ctl_wr_val : ctl_q;

    // status update: clear first, then events in order
    always_comb begin
        sts_nxt = sts_cleared;
        if (lock_tgl)
            sts_nxt[S_LOCK] = !sts_q[S_LOCK];
        if (detach_nxt) begin
            sts_nxt[S_PRES] = 1'b0;
            sts_nxt[S_PDC]  = 1'b1;
        end
        if (add_ok) begin
            sts_nxt[S_PRES] = 1'b1;
            sts_nxt[S_PDC]  = 1'b1;
            sts_nxt[S_BTN]  = 1'b1;
        end
        if (rem_ok || btn_push)
            sts_nxt[S_BTN] = 1'b1;
        if (pdc_in)
            sts_nxt[S_PDC] = 1'b1;
        if (ctl_hit)
            sts_nxt[S_CMD] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= CTL_RST;
            sts_q      <= 16'h0000;
            vec_q      <= '0;
            detach_req <= 1'b0;
            busy_err   <= 1'b0;
        end else begin
            ctl_q      <= ctl_nxt;
            sts_q      <= sts_nxt;
            detach_req <= detach_nxt;
            busy_err   <= busy_nxt;
            if (vec_we)
                vec_q <= vec_wr_val;
        end
    end
endmodule

// File: rtl/hp_notify.sv
module hp_notify
    import hp_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond_nxt,
    input  logic             cond_clr,
    input  logic             sts_hit,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] vec_q,
    output logic             msix_req,
    output logic             msi_req,
    output logic             intx,
    output logic [VEC_W-1:0] irq_vec
);
    notify_st_t state_q, state_d;
    logic       cond_ref, send;

    // reference: a status write silently updates the condition first
    assign cond_ref = sts_hit ? cond_clr : (state_q == N_RAISED);
    assign send     = (cond_nxt != cond_ref);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            N_QUIET:  if (cond_nxt)  state_d = N_RAISED;  // RAISE
            N_RAISED: if (!cond_nxt) state_d = N_QUIET;   // LOWER
            default:  state_d = N_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= N_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msix_req <= 1'b0;
            msi_req  <= 1'b0;
            intx     <= 1'b0;
            irq_vec  <= '0;
        end else begin
            msix_req <= send && msix_en;
            msi_req  <= send && !msix_en && msi_en;
            intx     <= cond_nxt && !msix_en && !msi_en;
            if (send)
                irq_vec <= vec_q;
        end
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int SLOT_ADDR  = 6,
    parameter int FLAGS_ADDR = 0,
    parameter int VEC_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic [ADDR_W-1:0] cfg_raddr,
    output logic [31:0]       cfg_rdata,
    input  logic              btn_push,
    input  logic              pdc_in,
    input  logic              add_req,
    input  logic              remove_req,
    input  logic              msix_en,
    input  logic              msi_en,
    output logic              busy_err,
    output logic              detach_req,
    output logic              msix_req,
    output logic              msi_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              intx
);
    logic        ctl_hit, sts_hit, vec_we, lock_tgl;
    logic [15:0] ctl_wr_val, sts_w1c;
    logic [15:0] ctl_q, sts_q, ctl_nxt, sts_nxt, sts_cleared;
    logic [VEC_W-1:0] vec_q;
    logic        cond_nxt, cond_clr;

    hp_cfg_decode #(
        .ADDR_W(ADDR_W), .SLOT_ADDR(SLOT_ADDR), .FLAGS_ADDR(FLAGS_ADDR)
    ) u_dec (
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .ctl_q(ctl_q), .ctl_hit(ctl_hit), .sts_hit(sts_hit), .vec_we(vec_we),
        .lock_tgl(lock_tgl), .ctl_wr_val(ctl_wr_val), .sts_w1c(sts_w1c)
    );

    hp_slot_regs #(.VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_hit(ctl_hit), .vec_we(vec_we), .lock_tgl(lock_tgl),
        .ctl_wr_val(ctl_wr_val), .sts_w1c(sts_w1c), .vec_wr_val(cfg_wdata[VEC_W-1:0]),
        .btn_push(btn_push), .pdc_in(pdc_in), .add_req(add_req), .remove_req(remove_req),
        .ctl_q(ctl_q), .sts_q(sts_q), .ctl_nxt(ctl_nxt), .sts_nxt(sts_nxt),
        .sts_cleared(sts_cleared), .vec_q(vec_q), .detach_req(detach_req), .busy_err(busy_err)
    );

    assign cond_nxt = notify_cond(ctl_nxt, sts_nxt);
    assign cond_clr = notify_cond(ctl_q, sts_cleared);

    hp_notify #(.VEC_W(VEC_W)) u_ntf (
        .clk(clk), .rst_n(rst_n), .cond_nxt(cond_nxt), .cond_clr(cond_clr),
        .sts_hit(sts_hit), .msix_en(msix_en), .msi_en(msi_en), .vec_q(vec_q),
        .msix_req(msix_req), .msi_req(msi_req), .intx(intx), .irq_vec(irq_vec)
    );

    always_comb begin
        if (cfg_raddr == ADDR_W'(SLOT_ADDR))
            cfg_rdata = {sts_q, ctl_q};
        else if (cfg_raddr == ADDR_W'(FLAGS_ADDR))
            cfg_rdata = 32'(vec_q);
        else
            cfg_rdata = 32'h0;
    end
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk
    import hp_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SLOT_ADDR = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msix_req,
    input logic              msi_req,
    input logic              intx,
    input logic              msix_en,
    input logic              msi_en,
    input logic              busy_err,
    input logic              detach_req,
    input logic              add_req,
    input logic              ctl_hit,
    input logic [15:0]       sts_q,
    input logic [ADDR_W-1:0] cfg_raddr,
    input logic [31:0]       cfg_rdata
);
    a_r8_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({msix_req, msi_req, intx}));

    a_r8_msix_first: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> !$past(msix_en));

    a_r9_intx_no_msg: assert property (@(posedge clk) disable iff (!rst_n)
        intx |-> $past(!msix_en && !msi_en));

    a_r3_cmd_done: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_hit) |-> sts_q[S_CMD]);

    a_r10_detach_state: assert property (@(posedge clk) disable iff (!rst_n)
        (detach_req && !$past(add_req)) |-> (!sts_q[S_PRES] && sts_q[S_PDC]));

    a_r12_busy_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |-> $past(sts_q[S_LOCK]));

    a_r2_lock_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_raddr == ADDR_W'(SLOT_ADDR)) |-> !cfg_rdata[C_LOCK_TGL]);
endmodule

bind hp_slot_ctrl hp_slot_chk #(.ADDR_W(ADDR_W), .SLOT_ADDR(SLOT_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .msix_req(msix_req), .msi_req(msi_req), .intx(intx),
    .msix_en(msix_en), .msi_en(msi_en), .busy_err(busy_err), .detach_req(detach_req),
    .add_req(add_req), .ctl_hit(ctl_hit), .sts_q(sts_q), .cfg_raddr(cfg_raddr),
    .cfg_rdata(cfg_rdata)
);

// File: tb/test_hp_slot_ctrl.sv
module test_hp_slot_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int SLOT   = 6;
    localparam int FLAGS  = 0;
    localparam int VEC_W  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [3:0] cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [ADDR_W-1:0] cfg_raddr = ADDR_W'(SLOT);
    logic [31:0] cfg_rdata;
    logic btn_push = 1'b0, pdc_in = 1'b0, add_req = 1'b0, remove_req = 1'b0;
    logic msix_en = 1'b0, msi_en = 1'b0;
    logic busy_err, detach_req, msix_req, msi_req, intx;
    logic [VEC_W-1:0] irq_vec;

    int vectors = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hp_slot_ctrl #(.ADDR_W(ADDR_W), .SLOT_ADDR(SLOT), .FLAGS_ADDR(FLAGS), .VEC_W(VEC_W)) i_hp_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .btn_push(btn_push), .pdc_in(pdc_in), .add_req(add_req), .remove_req(remove_req),
        .msix_en(msix_en), .msi_en(msi_en), .busy_err(busy_err), .detach_req(detach_req),
        .msix_req(msix_req), .msi_req(msi_req), .irq_vec(irq_vec), .intx(intx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; btn_push = 1'b0; pdc_in = 1'b0; add_req = 1'b0; remove_req = 1'b0;
    endtask

    task automatic wr(input int addr, input logic [3:0] be, input logic [31:0] data);
        cfg_wr = 1'b1; cfg_addr = ADDR_W'(addr); cfg_be = be; cfg_wdata = data;
        step();
    endtask

    function automatic logic [31:0] rd(input int addr);
        cfg_raddr = ADDR_W'(addr);
        return cfg_rdata;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] ctl;
        logic exp_c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cfg_raddr = ADDR_W'(SLOT); #1;
        chk("R1 slot dword", cfg_rdata, 32'h0000_0180);
        chk("R1 outputs", {29'b0, intx, msi_req, msix_req}, 32'h0);

        // R2/R3 byte enable 1 only
        wr(SLOT, 4'b0010, 32'hFFFF_FFFF); #1;
        chk("R2 R3 high byte write", rd(SLOT), 32'h0008_0F80);
        // R4 lock toggle, R2 low byte, lock bit reads 0
        wr(SLOT, 4'b0001, 32'h0000_0020); #1;
        chk("R4 lock set", rd(SLOT), 32'h0028_0F00);
        // R12 busy
        add_req = 1'b1; step(); #1;
        chk("R12 add busy", {31'b0, busy_err}, 32'h1);
        chk("R12 add rejected", rd(SLOT), 32'h0028_0F00);
        remove_req = 1'b1; step(); #1;
        chk("R12 remove busy", {31'b0, busy_err}, 32'h1);
        chk("R12 remove rejected", rd(SLOT), 32'h0028_0F00);
        wr(SLOT, 4'b0001, 32'h0000_0020); #1;
        chk("R4 lock released", rd(SLOT), 32'h0008_0F00);
        // R11 add
        add_req = 1'b1; step(); #1;
        chk("R11 add accepted", rd(SLOT), 32'h001D_0F00);
        chk("R11 no busy", {31'b0, busy_err}, 32'h0);
        // R10 detach
        wr(SLOT, 4'b0011, 32'h0000_0F80); #1;
        chk("R10 detach pulse", {31'b0, detach_req}, 32'h1);
        chk("R10 detach status", rd(SLOT), 32'h000D_0F80);
        step(); #1;
        chk("R10 detach one cycle", {31'b0, detach_req}, 32'h0);
        // R5 W1C keeps presence
        add_req = 1'b1; step();
        wr(SLOT, 4'b1100, 32'hFFFF_0000); #1;
        chk("R5 w1c", rd(SLOT), 32'h0010_0F80);
        // R13 event beats clear
        btn_push = 1'b1; wr(SLOT, 4'b1100, 32'h0001_0000); #1;
        chk("R13 set wins", rd(SLOT), 32'h0011_0F80);
        // R11 remove and pdc input
        wr(SLOT, 4'b1100, 32'h000D_0000);
        remove_req = 1'b1; pdc_in = 1'b1; step(); #1;
        chk("R11 remove/pdc", rd(SLOT), 32'h0015_0F80);

        // R6 R7 R8 R9 sweep: mode x enables x events
        for (int mode = 0; mode < 3; mode++) begin
            msix_en = (mode == 2); msi_en = (mode == 1);
            for (int en = 0; en < 16; en++) begin
                for (int ev = 0; ev < 8; ev++) begin
                    ctl = 16'h0180 | (16'(en[3]) << 4) | 16'(en[0]) | (16'(en[1]) << 2) | (16'(en[2]) << 3);
                    wr(SLOT, 4'b0011, {16'h0, ctl});
                    wr(SLOT, 4'b1100, 32'h000D_0000);
                    btn_push = ev[0]; pdc_in = ev[1];
                    if (ev[2]) begin
                        cfg_wr = 1'b1; cfg_addr = ADDR_W'(SLOT); cfg_be = 4'b0011; cfg_wdata = {16'h0, ctl};
                    end
                    step();
                    exp_c = en[3] && ((ev[0] && en[0]) || (ev[1] && en[1]) || (ev[2] && en[2]));
                    chk("R6 R7 R8 R9 sweep", {29'b0, msix_req, msi_req, intx},
                        {29'b0, exp_c && mode == 2, exp_c && mode == 1, exp_c && mode == 0});
                end
            end
        end

        // R8 vector and priority
        wr(FLAGS, 4'b0001, 32'h0000_0015);
        msix_en = 1'b1; msi_en = 1'b1;
        wr(SLOT, 4'b0011, 32'h0000_0191);
        wr(SLOT, 4'b1100, 32'h000D_0000);
        btn_push = 1'b1; step();
        chk("R8 msix over msi", {30'b0, msix_req, msi_req}, 32'h2);
        chk("R8 vector", 32'(irq_vec), 32'h15);
        step();
        chk("R8 one cycle pulse", {30'b0, msix_req, msi_req}, 32'h0);
        // R7 already-set event: nothing new
        msix_en = 1'b0;
        btn_push = 1'b1; step();
        chk("R7 repeat event silent", {30'b0, msix_req, msi_req}, 32'h0);
        // R7 status-clear drop silent
        wr(SLOT, 4'b1100, 32'h0001_0000);
        chk("R7 clear silent", {30'b0, msix_req, msi_req}, 32'h0);
        // R7 control-caused drop sends
        btn_push = 1'b1; step();
        chk("R7 rise msi", {30'b0, msix_req, msi_req}, 32'h1);
        wr(SLOT, 4'b0011, 32'h0000_0181);
        chk("R7 ctl drop msg", {30'b0, msix_req, msi_req}, 32'h1);
        // R9 INTx follows and drops on clear
        msi_en = 1'b0;
        wr(SLOT, 4'b0011, 32'h0000_0191);
        chk("R9 intx high", {31'b0, intx}, 32'h1);
        wr(SLOT, 4'b1100, 32'h0001_0000);
        chk("R9 intx drop", {31'b0, intx}, 32'h0);
        finish_run();
    end
endmodule